// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit decides whether a conditional branch is taken in a small accumulator processor with 8-bit data. The decoder supplies a branch kind code along with the operand values it has already fetched: the accumulator, the carry flag, a general register, an indirect byte, an immediate byte, a direct byte and one selected bit. The unit answers one clock later. It gives a taken flag and the side effects that some branch kinds carry: a register write-back strobe with the decremented count, a strobe that clears the tested bit, and a carry update.

The unit does not compute target addresses, fetch instructions or decode opcodes. When the unit reports not taken, the sequencer continues with the next sequential instruction. Every strobe is high for exactly the one cycle in which its result is presented.

Top module: `cbr_unit`

## Requirements
- R1: A request accepted with `req_valid` high at a clock edge shows its result on the outputs after the next rising edge, with `res_valid` high for one cycle. If there is no request, `res_valid`, `res_taken`, `reg_we`, `bit_clr` and `carry_we` are all low. After reset, all outputs are low.
- R2: Kind 0 is taken when `acc_val` is zero. Kind 1 is taken when `acc_val` is non-zero. No other operand affects these two kinds.
- R3: Kind 2 is taken when `carry_in` is 1. Kind 3 is taken when `carry_in` is 0.
- R4: For kind 4 (decrement and test), `reg_wdata` equals `reg_val` minus one. `reg_we` is high whether or not the branch is taken. The branch is taken when the decremented value is non-zero.
- R5: For kind 4, a `reg_val` of 0 decrements to 0xFF and the branch is taken. A `reg_val` of 1 decrements to 0 and the branch is not taken.
- R6: Kind 5 (compare) is taken when the left operand differs from the right operand. The left operand is selected by `cmp_lhs_sel`: 0 selects the accumulator, 1 the register, 2 the indirect byte, and 3 the accumulator. The right operand is selected by `cmp_rhs_sel`: 0 selects the immediate byte and 1 the direct byte.
- R7: Kind 5 raises `carry_we`. `carry_new` is 1 when the left operand is below the right operand as unsigned values, and 0 otherwise, including when the operands are equal.
- R8: Kind 6 is taken when `bit_val` is 1. Kind 7 is taken when `bit_val` is 0. Kind 8 is taken when `bit_val` is 1.
- R9: `bit_clr` is high only for kind 8 with `bit_val` equal to 1. A bit that is already 0 is never written.
- R10: Kind codes 9 to 15 are never taken and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 4 | Branch kind code |
| acc_val | input | 8 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| reg_val | input | 8 | Selected general register |
| ind_val | input | 8 | Byte read indirectly |
| imm_val | input | 8 | Immediate operand |
| dir_val | input | 8 | Byte read from a direct address |
| cmp_lhs_sel | input | 2 | Compare left operand select |
| cmp_rhs_sel | input | 1 | Compare right operand select |
| bit_val | input | 1 | Selected bit value |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Branch taken |
| reg_we | output | 1 | Register write-back strobe |
| reg_wdata | output | 8 | Decremented register value |
| bit_clr | output | 1 | Clear the tested bit |
| carry_we | output | 1 | Carry update strobe |
| carry_new | output | 1 | New carry value |

## Verification
The bench targets the decrement wrap from zero. A design that tests the old count, or that saturates the count at zero, would report the zero case as not taken or would write back 0 instead of 0xFF. It also checks that a count of one is not taken, and that the write-back strobe is present on that not-taken pass; a design that gated the write-back with the taken flag would leave the loop register unchanged. For compares it covers equal operands, where carry must clear, and each left operand and right operand source, so a design with swapped select codes or a signed compare would produce wrong decisions. It also applies the clear-type bit test to a bit that is already 0, where the design must stay silent, and it drives the unused kind codes, which must stay inert.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_ACC_ZERO   = 4'd0,
    K_ACC_NZERO  = 4'd1,
    K_CARRY_SET  = 4'd2,
    K_CARRY_CLR  = 4'd3,
    K_DEC_NZ     = 4'd4,
    K_CMP_NE     = 4'd5,
    K_BIT_ONE    = 4'd6,
    K_BIT_ZERO   = 4'd7,
    K_BIT_ONECLR = 4'd8
  } br_kind_e;

  typedef enum logic [1:0] {
    L_ACC  = 2'd0,
    L_REG  = 2'd1,
    L_IND  = 2'd2,
    L_ACC2 = 2'd3
  } lhs_sel_e;
endpackage

// File: rtl/cbr_operand_mux.sv
module cbr_operand_mux
  import cbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_val,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] ind_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] dir_val,
  input  logic [1:0]        lhs_sel,
  input  logic              rhs_sel,
  output logic [DATA_W-1:0] lhs,
  output logic [DATA_W-1:0] rhs
);
  always_comb begin
    unique case (lhs_sel_e'(lhs_sel))
      L_REG:   lhs = reg_val;
      L_IND:   lhs = ind_val;
      default: lhs = acc_val;
    endcase
    rhs = rhs_sel ? dir_val : imm_val;
  end
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [DATA_W-1:0] acc_val,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              bit_val,
  output logic              taken_c,
  output logic              reg_we_c,
  output logic [DATA_W-1:0] wdata_c,
  output logic              bit_clr_c,
  output logic              carry_we_c,
  output logic              carry_c
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] count_down(input logic [DATA_W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic below(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a < b;
  endfunction

  logic [DATA_W-1:0] dec_val;
  logic              dec_nz;
  logic              ops_differ;
  logic              lhs_below;
  logic              acc_is_zero;

  assign dec_val     = count_down(reg_val);
  assign dec_nz      = |dec_val;
  assign ops_differ  = lhs != rhs;
  assign lhs_below   = below(lhs, rhs);
  assign acc_is_zero = ~|acc_val;

  always_comb begin
    taken_c    = 1'b0;
    reg_we_c   = 1'b0;
    bit_clr_c  = 1'b0;
    carry_we_c = 1'b0;
    carry_c    = 1'b0;
    wdata_c    = dec_val;
    case (kind)
      K_ACC_ZERO:   taken_c = acc_is_zero;
      K_ACC_NZERO:  taken_c = ~acc_is_zero;
      K_CARRY_SET:  taken_c = carry_in;
      K_CARRY_CLR:  taken_c = ~carry_in;
      K_DEC_NZ: begin
        taken_c  = dec_nz;
        reg_we_c = 1'b1;
      end
      K_CMP_NE: begin
        taken_c    = ops_differ;
        carry_we_c = 1'b1;
        carry_c    = lhs_below;
      end
      K_BIT_ONE:    taken_c = bit_val;
      K_BIT_ZERO:   taken_c = ~bit_val;
      K_BIT_ONECLR: begin
        taken_c   = bit_val;
        bit_clr_c = bit_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbr_result_reg.sv
module cbr_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic              taken_c,
  input  logic              reg_we_c,
  input  logic [DATA_W-1:0] wdata_c,
  input  logic              bit_clr_c,
  input  logic              carry_we_c,
  input  logic              carry_c,
  output logic              res_valid,
  output logic              res_taken,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              bit_clr,
  output logic              carry_we,
  output logic              carry_new
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      bit_clr   <= 1'b0;
      carry_we  <= 1'b0;
      carry_new <= 1'b0;
    end else begin
      res_valid <= valid_in;
      res_taken <= valid_in & taken_c;
      reg_we    <= valid_in & reg_we_c;
      reg_wdata <= wdata_c;
      bit_clr   <= valid_in & bit_clr_c;
      carry_we  <= valid_in & carry_we_c;
      carry_new <= valid_in & carry_c;
    end
  end

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_taken || reg_we || bit_clr || carry_we));
  a_r9_clear_implies_taken: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clr |-> res_taken);
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic [DATA_W-1:0] acc_val,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] ind_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [DATA_W-1:0] dir_val,
  input  logic [1:0]        cmp_lhs_sel,
  input  logic              cmp_rhs_sel,
  input  logic              bit_val,
  output logic              res_valid,
  output logic              res_taken,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              bit_clr,
  output logic              carry_we,
  output logic              carry_new
);
  logic [DATA_W-1:0] lhs, rhs;
  logic              taken_c, reg_we_c, bit_clr_c, carry_we_c, carry_c;
  logic [DATA_W-1:0] wdata_c;

  cbr_operand_mux #(.DATA_W(DATA_W)) u_mux (
    .acc_val(acc_val), .reg_val(reg_val), .ind_val(ind_val),
    .imm_val(imm_val), .dir_val(dir_val),
    .lhs_sel(cmp_lhs_sel), .rhs_sel(cmp_rhs_sel),
    .lhs(lhs), .rhs(rhs)
  );

  cbr_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .kind(req_kind), .acc_val(acc_val), .carry_in(carry_in), .reg_val(reg_val),
    .lhs(lhs), .rhs(rhs), .bit_val(bit_val),
    .taken_c(taken_c), .reg_we_c(reg_we_c), .wdata_c(wdata_c),
    .bit_clr_c(bit_clr_c), .carry_we_c(carry_we_c), .carry_c(carry_c)
  );

  cbr_result_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .valid_in(req_valid),
    .taken_c(taken_c), .reg_we_c(reg_we_c), .wdata_c(wdata_c),
    .bit_clr_c(bit_clr_c), .carry_we_c(carry_we_c), .carry_c(carry_c),
    .res_valid(res_valid), .res_taken(res_taken), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .bit_clr(bit_clr), .carry_we(carry_we),
    .carry_new(carry_new)
  );

  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r4_dec_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_DEC_NZ) |=> (reg_we && reg_wdata == $past(reg_val) - DATA_W'(1)));
  a_r5_zero_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_DEC_NZ && reg_val == '0) |=> (res_taken && reg_wdata == '1));
  a_r9_no_clear_on_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bit_val) |=> !bit_clr);
  a_r10_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind > 4'd8) |=> !(res_taken || reg_we || bit_clr || carry_we));
endmodule

// File: tb/cbr_unit_test.sv
module cbr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_kind = '0;
  logic [W-1:0] acc_val = '0, reg_val = '0, ind_val = '0, imm_val = '0, dir_val = '0;
  logic carry_in = 1'b0, bit_val = 1'b0, cmp_rhs_sel = 1'b0;
  logic [1:0] cmp_lhs_sel = '0;
  logic res_valid, res_taken, reg_we, bit_clr, carry_we, carry_new;
  logic [W-1:0] reg_wdata;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic         tk;
    logic         rwe;
    logic [W-1:0] wd;
    logic         clr;
    logic         cwe;
    logic         cv;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .acc_val(acc_val), .carry_in(carry_in), .reg_val(reg_val), .ind_val(ind_val),
    .imm_val(imm_val), .dir_val(dir_val), .cmp_lhs_sel(cmp_lhs_sel),
    .cmp_rhs_sel(cmp_rhs_sel), .bit_val(bit_val),
    .res_valid(res_valid), .res_taken(res_taken), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .bit_clr(bit_clr), .carry_we(carry_we),
    .carry_new(carry_new)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] want, input string what);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, want);
    end
  endtask

  // Model written from the requirement list
  function automatic exp_t model(input int k, input logic [W-1:0] a, input logic c,
                                 input logic [W-1:0] r, input logic [W-1:0] ind,
                                 input logic [W-1:0] im, input logic [W-1:0] dr,
                                 input int ls, input logic rs, input logic b);
    exp_t e;
    int left, right, cnt;
    e = '0;
    left  = (ls == 1) ? int'(r) : (ls == 2) ? int'(ind) : int'(a);
    right = rs ? int'(dr) : int'(im);
    cnt   = (int'(r) + 255) % 256;
    if (k == 0) e.tk = (a == 0);
    if (k == 1) e.tk = (a != 0);
    if (k == 2) e.tk = c;
    if (k == 3) e.tk = !c;
    if (k == 4) begin e.rwe = 1; e.wd = W'(cnt); e.tk = (cnt != 0); end
    if (k == 5) begin e.tk = (left != right); e.cwe = 1; e.cv = (left < right); end
    if (k == 6) e.tk = b;
    if (k == 7) e.tk = !b;
    if (k == 8) begin e.tk = b; e.clr = b; end
    return e;
  endfunction

  task automatic issue(input string tag, input int k, input logic [W-1:0] a, input logic c,
                       input logic [W-1:0] r, input logic [W-1:0] ind, input logic [W-1:0] im,
                       input logic [W-1:0] dr, input int ls, input logic rs, input logic b);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'(k); acc_val = a; carry_in = c; reg_val = r;
    ind_val = ind; imm_val = im; dir_val = dr; cmp_lhs_sel = 2'(ls); cmp_rhs_sel = rs; bit_val = b;
    exp_q.push_back(model(k, a, c, r, ind, im, dr, ls, rs, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare each result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R1 unexpected result: got 1 expected 0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 16'(res_taken), 16'(e.tk), "taken");
        check(t, 16'(reg_we), 16'(e.rwe), "reg_we");
        if (e.rwe) check(t, 16'(reg_wdata), 16'(e.wd), "reg_wdata");
        check(t, 16'(bit_clr), 16'(e.clr), "bit_clr");
        check(t, 16'(carry_we), 16'(e.cwe), "carry_we");
        if (e.cwe) check(t, 16'(carry_new), 16'(e.cv), "carry_new");
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {10'd0, res_valid, res_taken, reg_we, bit_clr, carry_we, carry_new}, 16'd0, "reset outputs");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", {12'd0, res_valid, res_taken, reg_we, bit_clr}, 16'd0, "idle outputs");

    // R2 accumulator tests, other operands hostile
    issue("R2", 0, 8'h00, 1, 8'h05, 8'h11, 8'h22, 8'h33, 1, 0, 1);
    issue("R2", 0, 8'h34, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R2", 1, 8'h80, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R2", 1, 8'h00, 1, 8'hFF, 8'h01, 8'h01, 8'h01, 0, 0, 1);
    // R3 carry tests
    issue("R3", 2, 8'h00, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R3", 2, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
    issue("R3", 3, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R3", 3, 8'h55, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    // R4 decrement loop, R5 edges
    issue("R4", 4, 8'h00, 0, 8'h0A, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R4", 4, 8'h00, 0, 8'h80, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R5", 4, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R5", 4, 8'h07, 1, 8'h01, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R5", 4, 8'h00, 0, 8'h02, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    // R6 compare sources, R7 carry
    issue("R6", 5, 8'h40, 0, 8'h10, 8'h20, 8'h40, 8'h99, 0, 0, 0);
    issue("R6", 5, 8'h40, 0, 8'h10, 8'h20, 8'h40, 8'h10, 1, 1, 0);
    issue("R6", 5, 8'h40, 0, 8'h10, 8'h20, 8'h21, 8'h20, 2, 0, 0);
    issue("R6", 5, 8'h40, 0, 8'h10, 8'h20, 8'h40, 8'h00, 3, 0, 0);
    issue("R7", 5, 8'h7F, 1, 8'h00, 8'h00, 8'h80, 8'h00, 0, 0, 0);
    issue("R7", 5, 8'hF0, 0, 8'h00, 8'h00, 8'h0F, 8'h00, 0, 0, 0);
    issue("R7", 5, 8'h00, 1, 8'h30, 8'h00, 8'h00, 8'h30, 1, 1, 0);
    issue("R7", 5, 8'h00, 0, 8'h00, 8'hFF, 8'h00, 8'h01, 2, 1, 0);
    // R8 bit tests, R9 clear rule
    issue("R8", 6, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
    issue("R8", 6, 8'h00, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R8", 7, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    issue("R8", 7, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
    issue("R9", 8, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 1);
    issue("R9", 8, 8'h00, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    // R10 unused codes with every condition that could fire
    for (int k = 9; k < 16; k++)
      issue("R10", k, 8'h00, 1, 8'h00, 8'h01, 8'h02, 8'h03, 2, 1, 1);
    // R1 gap between requests then a lone request
    idle();
    idle();
    check("R1", {12'd0, res_valid, res_taken, reg_we, carry_we}, 16'd0, "gap outputs");
    issue("R1", 4, 8'h00, 0, 8'h03, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    idle();
    idle();
    idle();
    check("R1", 16'(exp_q.size()), 16'd0, "pending results");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule